// File: doc/BRIEF.md
# Fractional Byte Multiplier

This block multiplies two bytes inside a small 8-bit processor datapath. A three-bit mode code picks how each operand is read: both unsigned, both two's complement, or the first two's complement and the second unsigned. A separate mode bit asks for the fractional form of any of these, in which the 16-bit product moves one place to the left before it is written. This suits 1.7 fixed-point arithmetic.

An operation starts with a one-cycle start strobe. The operands and mode are captured on that clock edge. The product, split into a high and a low byte, appears on the next edge together with a one-cycle done pulse. Only two status flags are produced: carry and zero. The result and both flags keep their values until the next operation completes.

Top module: `frac_byte_mul`

## Requirements
- R1: After reset the high and low result bytes are 0x00, carry and zero are 0, and done is 0.
- R2: Mode 000 multiplies both operands as unsigned values and writes the 16-bit product (high byte on `prod_hi_o`, low byte on `prod_lo_o`).
- R3: Mode 001 multiplies both operands as two's-complement values.
- R4: Mode 010 multiplies a two's-complement first operand (`opa_i`) by an unsigned second operand (`opb_i`).
- R5: Modes 100, 101 and 110 are the fractional forms of 000, 001 and 010. In these modes the written value is the 16-bit product shifted left by one, with bit 0 cleared.
- R6: Carry is set to bit 15 of the product taken before any fractional shift.
- R7: Zero is set exactly when the 16-bit value written, after any shift, equals 0x0000.
- R8: Start is sampled on a clock edge. The result and flags update on the following edge, and done is high for that one cycle only.
- R9: A start that is sampled while an operation is in flight is ignored. It does not change the result of the operation in flight and does not produce a second done pulse.
- R10: The reserved codes 011 and 111 write 0x0000 to the result, leave carry and zero unchanged, and still give a done pulse.
- R11: The result and flags hold their values in every cycle in which done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled on each edge |
| mode_i | input | 3 | Mode code: bit 2 selects fractional; bits 1:0 give 00 unsigned, 01 signed, 10 signed-by-unsigned, 11 reserved |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| prod_hi_o | output | 8 | High byte of the result |
| prod_lo_o | output | 8 | Low byte of the result |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the mode and operands seen when start is accepted are the ones that govern the result. They also assume that start is a synchronous level free of X once reset has been released. The bench changes inputs only on falling edges and releases reset away from any rising edge. It drives start only in the cycles its tasks intend, with one exception: the busy-overlap case asserts start while an operation is in flight on purpose, to exercise the rule that such a start is ignored.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
    localparam int MODE_W = 3;

    // bits 1:0 select operand interpretation, bit 2 selects fractional shift
    localparam logic [1:0] KIND_UU  = 2'b00;
    localparam logic [1:0] KIND_SS  = 2'b01;
    localparam logic [1:0] KIND_SU  = 2'b10;
    localparam logic [1:0] KIND_RSV = 2'b11;

    function automatic logic mode_frac(input logic [MODE_W-1:0] m);
        return m[2];
    endfunction

    function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
        return m[1:0] == KIND_RSV;
    endfunction

    function automatic logic mode_sign_a(input logic [MODE_W-1:0] m);
        return (m[1:0] == KIND_SS) || (m[1:0] == KIND_SU);
    endfunction

    function automatic logic mode_sign_b(input logic [MODE_W-1:0] m);
        return m[1:0] == KIND_SS;
    endfunction
endpackage

// File: rtl/fbm_core.sv
module fbm_core #(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          sign_a_i,
    input  logic          sign_b_i,
    output logic [PW-1:0] raw_o
);
    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;

    // widen to full product width; modulo-2^PW product is exact for both signs
    always_comb begin
        ext_a = {{W{sign_a_i & a_i[W-1]}}, a_i};
        ext_b = {{W{sign_b_i & b_i[W-1]}}, b_i};
        raw_o = ext_a * ext_b;
    end
endmodule

// File: rtl/fbm_shape.sv
module fbm_shape #(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic [PW-1:0] raw_i,
    input  logic          frac_i,
    input  logic          rsv_i,
    output logic [PW-1:0] res_o,
    output logic          carry_o,
    output logic          zero_o,
    output logic          upd_flags_o
);
    always_comb begin
        carry_o     = raw_i[PW-1];
        upd_flags_o = !rsv_i;
        if (rsv_i) begin
            res_o = '0;
        end else if (frac_i) begin
            res_o = {raw_i[PW-2:0], 1'b0};
        end else begin
            res_o = raw_i;
        end
        zero_o = (res_o == '0);
    end
endmodule

// File: rtl/frac_byte_mul.sv
module frac_byte_mul
    import fbm_pkg::*;
#(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [W-1:0]      opa_i,
    input  logic [W-1:0]      opb_i,
    output logic [W-1:0]      prod_hi_o,
    output logic [W-1:0]      prod_lo_o,
    output logic              carry_o,
    output logic              zero_o,
    output logic              done_o
);
    typedef struct packed {
        logic              busy;
        logic [W-1:0]      a;
        logic [W-1:0]      b;
        logic [MODE_W-1:0] mode;
        logic [PW-1:0]     res;
        logic              carry;
        logic              zero;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    logic [PW-1:0] raw_w;
    logic [PW-1:0] res_w;
    logic          carry_w, zero_w, upd_w;

    fbm_core #(.W(W)) u_core (
        .a_i      (st_q.a),
        .b_i      (st_q.b),
        .sign_a_i (mode_sign_a(st_q.mode)),
        .sign_b_i (mode_sign_b(st_q.mode)),
        .raw_o    (raw_w)
    );

    fbm_shape #(.W(W)) u_shape (
        .raw_i       (raw_w),
        .frac_i      (mode_frac(st_q.mode)),
        .rsv_i       (mode_reserved(st_q.mode)),
        .res_o       (res_w),
        .carry_o     (carry_w),
        .zero_o      (zero_w),
        .upd_flags_o (upd_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.res  = res_w;
            if (upd_w) begin
                st_d.carry = carry_w;
                st_d.zero  = zero_w;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.a    = opa_i;
            st_d.b    = opb_i;
            st_d.mode = mode_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prod_hi_o = st_q.res[PW-1:W];
    assign prod_lo_o = st_q.res[W-1:0];
    assign carry_o   = st_q.carry;
    assign zero_o    = st_q.zero;
    assign done_o    = st_q.done;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(st_q.busy));
    // R9
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> !st_q.busy);
    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable({prod_hi_o, prod_lo_o}) && $stable(carry_o) && $stable(zero_o)));
    // R10
    reserved_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_reserved(st_q.mode)) |->
            ($stable(carry_o) && $stable(zero_o) && {prod_hi_o, prod_lo_o} == '0));
    // R5
    frac_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_frac(st_q.mode)) |-> !prod_lo_o[0]);
    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode_reserved(st_q.mode)) |-> (zero_o == ({prod_hi_o, prod_lo_o} == '0)));
endmodule

// File: tb/frac_byte_mul_bench.sv
module frac_byte_mul_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] mode = 3'b000;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic [7:0] hi, lo;
    logic       carry, zero, done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frac_byte_mul u_frac_byte_mul (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .opa_i(opa), .opb_i(opb), .prod_hi_o(hi), .prod_lo_o(lo),
        .carry_o(carry), .zero_o(zero), .done_o(done)
    );

    // {mode, a, b, expected product, carry, zero}
    localparam logic [36:0] VEC [NVEC] = '{
        {3'b000, 8'hFF, 8'hFF, 16'hFE01, 1'b1, 1'b0},   // R2
        {3'b000, 8'h0C, 8'h0A, 16'h0078, 1'b0, 1'b0},   // R2
        {3'b000, 8'h00, 8'h5A, 16'h0000, 1'b0, 1'b1},   // R7
        {3'b001, 8'hFF, 8'hFF, 16'h0001, 1'b0, 1'b0},   // R3
        {3'b001, 8'h80, 8'h7F, 16'hC080, 1'b1, 1'b0},   // R3
        {3'b010, 8'hFF, 8'hFF, 16'hFF01, 1'b1, 1'b0},   // R4
        {3'b010, 8'h7F, 8'hFF, 16'h7E81, 1'b0, 1'b0},   // R4
        {3'b100, 8'hFF, 8'h81, 16'h00FE, 1'b1, 1'b0},   // R5 R6
        {3'b101, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},   // R5 R6
        {3'b110, 8'h80, 8'h40, 16'hC000, 1'b1, 1'b0},   // R5 R6
        {3'b101, 8'h40, 8'h00, 16'h0000, 1'b0, 1'b1}    // R5 R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drives one operation; returns at the falling edge where done should be high
    task automatic run_op(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        start = 1'b1; mode = m; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        check("R8 done low while busy", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R8 done high on second edge", {31'd0, done}, 32'd1);
    endtask

    task automatic check_result(input string req, input logic [15:0] p, input logic c, input logic z);
        check(req, {16'd0, hi, lo}, {16'd0, p});
        check("R6 carry", {31'd0, carry}, {31'd0, c});
        check("R7 zero", {31'd0, zero}, {31'd0, z});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 result", {16'd0, hi, lo}, 32'd0);
        check("R1 carry", {31'd0, carry}, 32'd0);
        check("R1 zero", {31'd0, zero}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_op(VEC[i][36:34], VEC[i][33:26], VEC[i][25:18]);
            check_result("R2-R5 vector product", VEC[i][17:2], VEC[i][1], VEC[i][0]);
            @(negedge clk);
            check("R8 done single pulse", {31'd0, done}, 32'd0);
        end

        // R10: reserved 011 after a carry-set result keeps C=1 Z=0
        run_op(3'b000, 8'hFF, 8'hFF);
        run_op(3'b011, 8'h12, 8'h34);
        check("R10 reserved result", {16'd0, hi, lo}, 32'd0);
        check("R10 reserved carry kept", {31'd0, carry}, 32'd1);
        check("R10 reserved zero kept", {31'd0, zero}, 32'd0);

        // R10: reserved 111 after a zero result keeps C=0 Z=1
        run_op(3'b000, 8'h00, 8'h11);
        run_op(3'b111, 8'hFF, 8'hFF);
        check("R10 reserved result", {16'd0, hi, lo}, 32'd0);
        check("R10 reserved carry kept", {31'd0, carry}, 32'd0);
        check("R10 reserved zero kept", {31'd0, zero}, 32'd1);

        // R9: start during busy is ignored
        @(negedge clk);
        start = 1'b1; mode = 3'b000; opa = 8'h02; opb = 8'h03;
        @(negedge clk);
        opa = 8'hFF; opb = 8'hFF; mode = 3'b001;
        @(negedge clk);
        start = 1'b0;
        check("R9 done for first op", {31'd0, done}, 32'd1);
        check("R9 busy start ignored", {16'd0, hi, lo}, 32'h0006);
        @(negedge clk);
        check("R9 no second done", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R9 no second done later", {31'd0, done}, 32'd0);
        check("R9 result kept", {16'd0, hi, lo}, 32'h0006);

        // R11: outputs hold while inputs move without start
        run_op(3'b010, 8'hFF, 8'hFF);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            opa = opa + 8'h13; opb = opb ^ 8'h5A; mode = mode + 3'd1;
        end
        check("R11 result held", {16'd0, hi, lo}, 32'hFF01);
        check("R11 carry held", {31'd0, carry}, 32'd1);
        check("R11 zero held", {31'd0, zero}, 32'd0);

        finish_run();
    end
endmodule